// File: doc/BRIEF.md
# Strap-Configured Power-Up Sequencer

This controller brings a data converter out of reset when its features are set by strap pins rather than by software. While the reset input is low, every output holds its default value. After reset is released (the release is synchronized to the system clock), the block sits in a low-power state for a fixed number of audio sample periods. It then captures the strap pins as the device configuration and raises a digital request to quick-charge the analog reference. After a programmable number of further sample periods, it declares the device ready.

Sample periods are counted on a single-cycle strobe that the sample clock domain supplies, not on system clocks. The straps must hold still while the reference charges. If a change is seen during that phase, the block recaptures the new value, raises a sticky error flag and restarts the ready count. Once ready is reached, the configuration is frozen and the ready flag holds until the next reset.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_ni` is low, `low_power_o`=1, `vref_chg_o`=0, `ready_o`=0, `cfg_o`=0 and `strap_err_o`=0. Assertion of `rst_ni` takes effect without waiting for a clock edge.
- R2: The release of `rst_ni` passes through a two-flop synchronizer. A strobe sampled on the first clock edge after release is not counted. After release the block stays in low power (`low_power_o`=1, `vref_chg_o`=0) until it has counted LP_PERIODS strobes.
- R3: On the clock edge that samples the LP_PERIODS-th strobe, `low_power_o` falls, `vref_chg_o` rises and `cfg_o` captures `strap_i`. Exactly one of `low_power_o`, `vref_chg_o` and `ready_o` is high at any time out of reset.
- R4: On the clock edge that samples the READY_PERIODS-th strobe counted in the charge phase, `ready_o` rises and `vref_chg_o` falls.
- R5: In the charge phase, a cycle where `strap_i` differs from `cfg_o` loads `strap_i` into `cfg_o` and clears the strobe count. A strobe in that same cycle is not counted, so READY_PERIODS further strobes are needed before ready.
- R6: `strap_err_o` is set by any strap change that R5 detects, and it stays high until reset.
- R7: Once high, `ready_o` stays high until reset. In the ready state, strap changes alter neither `cfg_o` nor `strap_err_o`.
- R8: Strap changes during the low-power phase do not set `strap_err_o`. `cfg_o` takes the value present on the edge that ends that phase.
- R9: The sequence advances only on cycles where `fs_stb_i` is high. Any number of clocks without a strobe leaves the phase and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assertion |
| fs_stb_i | input | 1 | One-cycle pulse per audio sample period |
| strap_i | input | STRAP_W | Hardware configuration strap pins |
| cfg_o | output | STRAP_W | Captured configuration |
| low_power_o | output | 1 | Device held in low-power state |
| vref_chg_o | output | 1 | Reference quick-charge request |
| ready_o | output | 1 | Power-up complete |
| strap_err_o | output | 1 | Sticky flag: straps moved during charge |

## Verification
Every cycle, the assertions check the following. Exactly one phase flag is high. Ready and the error flag never fall outside reset. The strobe counter advances by one per counted strobe and otherwise holds. The configuration holds outside its capture windows. Each phase is entered only on a strobe. The exact number of strobes to each phase change can only be shown by the bench's scenarios. The same holds for the restart after a strap change at different points of the charge, including a change coinciding with a strobe, and for the strobe lost during synchronized reset release.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [1:0] {
    ST_LOWPWR = 2'd0,
    ST_CHARGE = 2'd1,
    ST_READY  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pwrup_stb_cnt.sv
module pwrup_stb_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  p_count_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  p_count_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pwrup_strap_reg.sv
module pwrup_strap_reg #(
  parameter int STRAP_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               watch_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] cfg_o,
  output logic               mismatch_o,
  output logic               err_o
);
  logic [STRAP_W-1:0] cfg_q;
  logic               err_q;

  assign mismatch_o = watch_i && (strap_i != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (load_i || mismatch_o) cfg_q <= strap_i;
      if (mismatch_o)           err_q <= 1'b1;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !watch_i) |=> $stable(cfg_o));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int STRAP_W       = 4,
  parameter int LP_PERIODS    = 1,
  parameter int READY_PERIODS = 2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fs_stb_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] cfg_o,
  output logic               low_power_o,
  output logic               vref_chg_o,
  output logic               ready_o,
  output logic               strap_err_o
);
  import pwrup_pkg::*;

  localparam int MAX_PERIODS = (READY_PERIODS > LP_PERIODS) ? READY_PERIODS : LP_PERIODS;
  localparam int CNT_W       = (MAX_PERIODS > 1) ? $clog2(MAX_PERIODS) : 1;
  localparam logic [CNT_W-1:0] LP_LAST    = CNT_W'(LP_PERIODS - 1);
  localparam logic [CNT_W-1:0] READY_LAST = CNT_W'(READY_PERIODS - 1);

  logic             rst_n_s;
  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             lp_done, chg_done, mismatch;

  pwrup_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  assign lp_done  = (state_q == ST_LOWPWR) && fs_stb_i && (cnt == LP_LAST);
  // a strap change in the same cycle wins over a strobe
  assign chg_done = (state_q == ST_CHARGE) && fs_stb_i && !mismatch && (cnt == READY_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOWPWR: if (lp_done)  state_d = ST_CHARGE;
      ST_CHARGE: if (chg_done) state_d = ST_READY;
      ST_READY:  state_d = ST_READY;
      default:   state_d = ST_LOWPWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_LOWPWR;
    else          state_q <= state_d;
  end

  pwrup_stb_cnt #(.CNT_W(CNT_W)) i_stb_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .clr_i  (lp_done || chg_done || mismatch),
    .inc_i  (fs_stb_i && (state_q != ST_READY)),
    .cnt_o  (cnt)
  );

  pwrup_strap_reg #(.STRAP_W(STRAP_W)) i_strap_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .load_i     (lp_done),
    .watch_i    (state_q == ST_CHARGE),
    .strap_i    (strap_i),
    .cfg_o      (cfg_o),
    .mismatch_o (mismatch),
    .err_o      (strap_err_o)
  );

  assign low_power_o = (state_q == ST_LOWPWR);
  assign vref_chg_o  = (state_q == ST_CHARGE);
  assign ready_o     = (state_q == ST_READY);

  p_one_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $countones({low_power_o, vref_chg_o, ready_o}) == 1);

  p_charge_on_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(vref_chg_o) |-> ($past(low_power_o) && $past(fs_stb_i)));

  p_ready_on_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(ready_o) |-> ($past(vref_chg_o) && $past(fs_stb_i)));

  p_ready_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ready_o |=> ready_o);

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (vref_chg_o && (strap_i != cfg_o)) |=> (vref_chg_o && strap_err_o));
endmodule

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
module test_pwrup_seq;
  localparam int SW = 4;
  localparam int LP = 2;
  localparam int RP = 16;

  typedef struct packed {
    logic [SW-1:0] s0;
    logic [7:0]    chg_at;   // 8'hFF: no change
    logic [SW-1:0] s1;
    logic [7:0]    n_stb;
    logic          err;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{4'h5, 8'hFF, 4'h5, 8'd16, 1'b0},
    '{4'hA, 8'd5,  4'h3, 8'd21, 1'b1},
    '{4'hF, 8'd0,  4'h0, 8'd16, 1'b1},
    '{4'h6, 8'd15, 4'h9, 8'd31, 1'b1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fs_stb_i = 1'b0;
  logic [SW-1:0] strap_i = '0;
  logic [SW-1:0] cfg_o;
  logic          low_power_o, vref_chg_o, ready_o, strap_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  pwrup_seq #(.STRAP_W(SW), .LP_PERIODS(LP), .READY_PERIODS(RP)) i_pwrup_seq (
    .clk_i, .rst_ni, .fs_stb_i, .strap_i,
    .cfg_o, .low_power_o, .vref_chg_o, .ready_o, .strap_err_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic strobe();
    @(negedge clk_i) fs_stb_i = 1'b1;
    @(negedge clk_i) fs_stb_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; fs_stb_i = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick(3);
  endtask

  task automatic to_charge(logic [SW-1:0] s);
    strap_i = s;
    repeat (LP) strobe();
  endtask

  initial begin
    // R1: reset defaults
    strap_i = 4'hC;
    tick(3);
    chk("R1 low_power", low_power_o, 1);
    chk("R1 charge", vref_chg_o, 0);
    chk("R1 ready", ready_o, 0);
    chk("R1 cfg", cfg_o, 0);
    chk("R1 err", strap_err_o, 0);

    // R2: strobe on first edge after release is ignored
    rst_ni = 1'b1; fs_stb_i = 1'b1;
    @(negedge clk_i) fs_stb_i = 1'b0;
    tick(2);
    strobe();
    chk("R2 still low power", low_power_o, 1);
    chk("R2 no charge", vref_chg_o, 0);
    strobe();
    chk("R3 charge entered", vref_chg_o, 1);
    chk("R3 low power left", low_power_o, 0);
    chk("R3 cfg captured", cfg_o, 4'hC);

    // table walk: R3 R4 R5 R6
    foreach (VEC[i]) begin
      do_reset();
      to_charge(VEC[i].s0);
      chk("R3 cfg at charge", cfg_o, VEC[i].s0);
      for (int k = 0; k < int'(VEC[i].n_stb) - 1; k++) begin
        if (k == int'(VEC[i].chg_at)) begin
          @(negedge clk_i) strap_i = VEC[i].s1;
        end
        strobe();
      end
      chk("R4/R5 not ready before last strobe", ready_o, 0);
      strobe();
      chk("R4 ready", ready_o, 1);
      chk("R4 charge dropped", vref_chg_o, 0);
      chk("R5 cfg", cfg_o, VEC[i].s1);
      chk("R6 err", strap_err_o, VEC[i].err);
    end

    // R8: strap moves during low power
    do_reset();
    strap_i = 4'h1;
    strobe();
    strap_i = 4'h2;
    tick(1);
    strobe();
    chk("R8 cfg takes late value", cfg_o, 4'h2);
    chk("R8 no error", strap_err_o, 0);

    // R9: no progress without strobes
    tick(100);
    chk("R9 still charging", vref_chg_o, 1);
    repeat (RP - 1) strobe();
    tick(50);
    chk("R9 not ready", ready_o, 0);
    strobe();
    chk("R9 ready after last strobe", ready_o, 1);

    // R7: straps ignored once ready
    strap_i = 4'hE;
    tick(2);
    repeat (3) strobe();
    chk("R7 ready held", ready_o, 1);
    chk("R7 cfg frozen", cfg_o, 4'h2);
    chk("R7 no error", strap_err_o, 0);

    // R5: strap change coinciding with a strobe discards it
    do_reset();
    to_charge(4'h4);
    repeat (3) strobe();
    @(negedge clk_i) begin strap_i = 4'h7; fs_stb_i = 1'b1; end
    @(negedge clk_i) fs_stb_i = 1'b0;
    chk("R6 err set", strap_err_o, 1);
    repeat (RP - 1) strobe();
    chk("R5 coincident strobe not counted", ready_o, 0);
    chk("R6 err held", strap_err_o, 1);
    strobe();
    chk("R5 ready", ready_o, 1);
    chk("R5 cfg", cfg_o, 4'h7);

    // R1: asynchronous reset from ready
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async ready", ready_o, 0);
    chk("R1 async low_power", low_power_o, 1);
    chk("R1 async err", strap_err_o, 0);
    chk("R1 async cfg", cfg_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule